// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block collects up to eight interrupt request lines, latches each rising edge as a pending request, and presents a single interrupt to a processor. The highest-priority request is chosen among those that are pending and not masked. A request is held back while an equal or more urgent level is still in service. When the processor acknowledges, the block returns an 8-bit vector formed from a programmable base and the number of the winning line. The state then moves from pending to in-service, unless automatic end-of-interrupt is enabled.

Software reaches the block through two byte-wide ports. The command port (`addr` = 0) takes the opening word of the setup sequence, a readback selector and end-of-interrupt commands. Reads from it return either the pending set or the in-service set. The data port (`addr` = 1) takes the remaining setup words and, in normal operation, the mask. Reads from it return the mask. Reads are combinational. Writes take effect on the clock edge that samples `wr_en`.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF with every line masked. A command-port read returns the pending set. Automatic end-of-interrupt is on, so an acknowledge leaves the in-service set at zero. `int_out` is low.
- R2: A pending bit is set by a 0-to-1 transition on its input line. It stays set until that line is acknowledged. A line still held high after its acknowledge does not set it again.
- R3: In normal operation a data-port write loads the mask, where bit i = 1 disables line i. A masked pending line never raises `int_out`. A data-port read returns the mask.
- R4: The winning request is the lowest-numbered line that is pending and unmasked, so line 0 is most urgent. `vec_out` equals the base OR'd with the 3-bit line number.
- R5: `int_out` stays low while any in-service bit sits at a position less than or equal to the winning line's number.
- R6: An acknowledge (`int_ack` high while `int_out` is high) clears the winner's pending bit on the next edge. It sets the winner's in-service bit only when automatic end-of-interrupt is off.
- R7: A command-port write with bit 4 = 1 starts setup. The next data-port write loads the vector base. The data-port write after that is absorbed with no effect on the mask. Normal operation then resumes.
- R8: If bit 0 of the starting word was 1, the first data-port write after setup sets automatic end-of-interrupt from its bit 1 and leaves the mask unchanged. If bit 0 was 0, that write loads the mask.
- R9: A command-port write with bit 4 = 0 and bit 3 = 1 selects readback. Bit 0 = 1 returns the pending set and bit 0 = 0 returns the in-service set.
- R10: A command-port write with bits 4:3 = 00 and bits 7:5 = 001 clears the lowest-numbered set in-service bit.
- R11: A command-port write with bits 4:3 = 00 and bits 7:5 = 011 clears the in-service bit selected by bits 2:0.
- R12: A command-port write with bits 4:3 = 00 and any other value of bits 7:5 leaves the in-service set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| wr_en | input | 1 | Write strobe for the selected port |
| addr | input | 1 | Port select: 0 command, 1 data |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the selected port |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge |
| vec_out | output | 8 | Vector of the current winner |

## Verification
On every cycle the assertions check the following:
- `int_out` is never raised for a masked line or over an in-service level of equal or higher priority.
- An acknowledge removes the winner's pending bit.
- Automatic end-of-interrupt never adds in-service bits.
- The setup sequencer moves to the base step on the opening word.
- A normal data write loads the mask.

Only the bench's scenarios can show the following:
- The setup sequence absorbs the cascade word.
- The optional fourth word is steered away from the mask.
- Each end-of-interrupt code has its effect on readback.
- A held-high line is not re-latched.
- Higher-priority preemption produces the right vector.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;

    typedef enum logic [1:0] {
        STEP_RUN  = 2'd0,
        STEP_BASE = 2'd1,
        STEP_CASC = 2'd2
    } init_step_e;

    typedef enum logic [1:0] {
        EOI_NONE   = 2'd0,
        EOI_LOWEST = 2'd1,
        EOI_INDEX  = 2'd2
    } eoi_kind_e;

endpackage

// File: rtl/irqc_edge.sv
`timescale 1ns/1ps
module irqc_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lines;
        rise   = lines & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irqc_cfg.sv
`timescale 1ns/1ps
module irqc_cfg
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [DW-1:0]    wr_data,
    output logic [N-1:0]     mask,
    output logic [DW-1:0]    base,
    output logic             aeoi,
    output logic             sel_pend,
    output eoi_kind_e        eoi_kind,
    output logic [IDX_W-1:0] eoi_idx
);
    typedef struct packed {
        logic [N-1:0]  mask;
        logic [DW-1:0] base;
        logic          aeoi;
        logic          sel_pend;
        logic          want4;
        init_step_e    step;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        eoi_kind = EOI_NONE;
        eoi_idx  = wr_data[IDX_W-1:0];
        if (wr_en && !addr) begin
            if (wr_data[4]) begin
                cfg_d.want4 = wr_data[0];
                cfg_d.step  = STEP_BASE;
            end else if (wr_data[3]) begin
                cfg_d.sel_pend = wr_data[0];
            end else if (wr_data[7:5] == 3'b001) begin
                eoi_kind = EOI_LOWEST;
            end else if (wr_data[7:5] == 3'b011) begin
                eoi_kind = EOI_INDEX;
            end
        end else if (wr_en && addr) begin
            case (cfg_q.step)
                STEP_BASE: begin
                    cfg_d.base = wr_data;
                    cfg_d.step = STEP_CASC;
                end
                STEP_CASC: cfg_d.step = STEP_RUN;
                default: begin
                    if (cfg_q.want4) begin
                        cfg_d.aeoi  = wr_data[1];
                        cfg_d.want4 = 1'b0;
                    end else begin
                        cfg_d.mask = wr_data[N-1:0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask     <= '1;
            cfg_q.base     <= '0;
            cfg_q.aeoi     <= 1'b1;
            cfg_q.sel_pend <= 1'b1;
            cfg_q.want4    <= 1'b0;
            cfg_q.step     <= STEP_RUN;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask     = cfg_q.mask;
    assign base     = cfg_q.base;
    assign aeoi     = cfg_q.aeoi;
    assign sel_pend = cfg_q.sel_pend;

    p_init_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wr_data[4]) |=> (cfg_q.step == STEP_BASE));

    p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && cfg_q.step == STEP_RUN && !cfg_q.want4)
        |=> (mask == $past(wr_data[N-1:0])));
endmodule

// File: rtl/irqc_resolver.sv
`timescale 1ns/1ps
module irqc_resolver #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     insvc,
    input  logic [N-1:0]     mask,
    output logic             req,
    output logic [IDX_W-1:0] win
);
    logic [N-1:0]     live;
    logic [IDX_W-1:0] svc_low;

    always_comb begin
        live    = pend & ~mask;
        win     = '0;
        svc_low = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i])  win     = IDX_W'(i);
            if (insvc[i]) svc_low = IDX_W'(i);
        end
        req = (live != '0) && !((insvc != '0) && (svc_low <= win));
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          int_out,
    input  logic          int_ack,
    output logic [DW-1:0] vec_out
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] insvc;
    } core_t;

    core_t            core_d, core_q;
    logic [N-1:0]     rise, mask;
    logic [DW-1:0]    base;
    logic             aeoi, sel_pend, ack_go;
    eoi_kind_e        eoi_kind;
    logic [IDX_W-1:0] eoi_idx, win;
    logic [N-1:0]     ack_bit, eoi_clr;

    irqc_edge #(.N(N)) u_edge (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .rise(rise)
    );

    irqc_cfg #(.N(N), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .mask(mask), .base(base), .aeoi(aeoi),
        .sel_pend(sel_pend), .eoi_kind(eoi_kind), .eoi_idx(eoi_idx)
    );

    irqc_resolver #(.N(N)) u_res (
        .pend(core_q.pend), .insvc(core_q.insvc), .mask(mask),
        .req(int_out), .win(win)
    );

    always_comb begin
        ack_go  = int_ack && int_out;
        ack_bit = ack_go ? (N'(1) << win) : '0;
        case (eoi_kind)
            EOI_LOWEST: eoi_clr = core_q.insvc & ~(core_q.insvc - N'(1));
            EOI_INDEX:  eoi_clr = N'(1) << eoi_idx;
            default:    eoi_clr = '0;
        endcase
        core_d.pend  = (core_q.pend & ~ack_bit) | rise;
        core_d.insvc = (core_q.insvc & ~eoi_clr) | (aeoi ? '0 : ack_bit);
        vec_out = base | DW'(win);
        if (addr)          rd_data = DW'(mask);
        else if (sel_pend) rd_data = DW'(core_q.pend);
        else               rd_data = DW'(core_q.insvc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    logic [N-1:0] upto_win;
    always_comb begin
        for (int i = 0; i < N; i++) upto_win[i] = (i <= int'(win));
    end

    p_unmasked_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((core_q.pend & ~mask) != '0));

    p_svc_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((core_q.insvc & upto_win) == '0));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_go |=> ((core_q.pend & $past(ack_bit & ~rise)) == '0));

    p_aeoi_no_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        aeoi |=> ((core_q.insvc & ~$past(core_q.insvc)) == '0));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = 8'h00;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, vec_out;
    logic       int_out;
    logic       int_ack = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .int_out(int_out), .int_ack(int_ack), .vec_out(vec_out)
    );

    // behavioural reference model
    bit [7:0] m_pend, m_svc, m_mask, m_base, m_prev;
    bit       m_aeoi, m_selp, m_want4;
    int       m_step;

    function automatic int m_pick();
        for (int i = 0; i < 8; i++) if (m_pend[i] && !m_mask[i]) return i;
        return -1;
    endfunction

    function automatic bit m_int();
        int p = m_pick();
        if (p < 0) return 1'b0;
        for (int j = 0; j <= p; j++) if (m_svc[j]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit [7:0] m_rd();
        if (addr) return m_mask;
        return m_selp ? m_pend : m_svc;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = 0; m_svc = 0; m_mask = 8'hFF; m_base = 0; m_prev = 0;
            m_aeoi = 1; m_selp = 1; m_want4 = 0; m_step = 0;
        end else begin
            automatic int p = m_pick();
            automatic bit go = int_ack && m_int();
            automatic bit [7:0] np = m_pend;
            automatic bit [7:0] ns = m_svc;
            if (wr_en && !addr && !wr_data[4] && !wr_data[3]) begin
                if (wr_data[7:5] == 3'd1) begin
                    for (int i = 0; i < 8; i++)
                        if (m_svc[i]) begin ns[i] = 0; break; end
                end else if (wr_data[7:5] == 3'd3) begin
                    ns[wr_data[2:0]] = 0;
                end
            end
            if (go) begin
                np[p] = 0;
                if (!m_aeoi) ns[p] = 1;
            end
            for (int i = 0; i < 8; i++) if (irq_in[i] && !m_prev[i]) np[i] = 1;
            if (wr_en && !addr) begin
                if (wr_data[4]) begin m_want4 = wr_data[0]; m_step = 1; end
                else if (wr_data[3]) m_selp = wr_data[0];
            end else if (wr_en && addr) begin
                if (m_step == 1) begin m_base = wr_data; m_step = 2; end
                else if (m_step == 2) m_step = 0;
                else if (m_want4) begin m_aeoi = wr_data[1]; m_want4 = 0; end
                else m_mask = wr_data;
            end
            m_pend = np; m_svc = ns; m_prev = irq_in;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_n && !done) begin
                chk("model int_out", {7'd0, int_out}, {7'd0, m_int()});
                chk("model rd_data", rd_data, m_rd());
                if (m_int()) chk("model vec_out", vec_out, m_base | 8'(m_pick()));
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(bit a, bit [7:0] d);
        cyc(); addr = a; wr_data = d; wr_en = 1'b1;
        cyc(); wr_en = 1'b0;
    endtask

    task automatic rdchk(string tag, bit a, bit [7:0] exp);
        cyc(); addr = a; #3;
        chk(tag, rd_data, exp);
    endtask

    task automatic intchk(string tag, bit exp_int, bit [7:0] exp_vec);
        cyc(); #3;
        chk({tag, " int"}, {7'd0, int_out}, {7'd0, exp_int});
        if (exp_int) chk({tag, " vec"}, vec_out, exp_vec);
    endtask

    task automatic ack();
        cyc(); int_ack = 1'b1;
        cyc(); int_ack = 1'b0;
    endtask

    task automatic lines(bit [7:0] v);
        cyc(); irq_in = v;
        cyc();
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1: reset values
        rdchk("R1 mask", 1'b1, 8'hFF);
        rdchk("R1 pend sel", 1'b0, 8'h00);
        intchk("R1", 1'b0, 8'h00);
        // R1: auto-EOI on after reset
        wr(1'b1, 8'hFE);
        lines(8'h01);
        intchk("R1 line0", 1'b1, 8'h00);
        ack();
        wr(1'b0, 8'h0A);
        rdchk("R1 aeoi svc", 1'b0, 8'h00);
        lines(8'h00);
        // R7/R8: setup with fourth word
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'hAA);
        rdchk("R7 cascade ignored", 1'b1, 8'hFE);
        wr(1'b1, 8'h00);
        rdchk("R8 fourth word not mask", 1'b1, 8'hFE);
        wr(1'b1, 8'h00);
        rdchk("R3 mask load", 1'b1, 8'h00);
        // R4/R6/R5
        lines(8'h28);
        intchk("R4 line3", 1'b1, 8'h43);
        ack();
        wr(1'b0, 8'h0A);
        rdchk("R6 svc set", 1'b0, 8'h08);
        intchk("R5 line5 blocked", 1'b0, 8'h00);
        wr(1'b0, 8'h0B);
        rdchk("R9 R6 pend cleared", 1'b0, 8'h20);
        lines(8'h2A);
        intchk("R4 R5 line1 preempts", 1'b1, 8'h41);
        ack();
        wr(1'b0, 8'h0A);
        rdchk("R9 svc sel", 1'b0, 8'h0A);
        // R10/R11/R12
        wr(1'b0, 8'h20);
        rdchk("R10 lowest eoi", 1'b0, 8'h08);
        intchk("R5 still blocked", 1'b0, 8'h00);
        wr(1'b0, 8'h63);
        rdchk("R11 indexed eoi", 1'b0, 8'h00);
        intchk("R4 line5", 1'b1, 8'h45);
        ack();
        rdchk("R6 svc line5", 1'b0, 8'h20);
        wr(1'b0, 8'h45);
        rdchk("R12 code 010", 1'b0, 8'h20);
        wr(1'b0, 8'hE5);
        rdchk("R12 code 111", 1'b0, 8'h20);
        wr(1'b0, 8'h0B);
        rdchk("R2 held line not relatched", 1'b0, 8'h00);
        wr(1'b0, 8'h65);
        // R3: masked line pends but no interrupt
        wr(1'b1, 8'h40);
        lines(8'h6A);
        rdchk("R3 pend masked", 1'b0, 8'h40);
        intchk("R3 masked", 1'b0, 8'h00);
        wr(1'b1, 8'h00);
        intchk("R3 unmasked", 1'b1, 8'h46);
        ack();
        wr(1'b0, 8'h20);
        // R8: setup without fourth word
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h80);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h0F);
        rdchk("R8 no fourth word", 1'b1, 8'h0F);
        lines(8'h7A);
        intchk("R7 new base", 1'b1, 8'h84);
        ack();
        wr(1'b0, 8'h0A);
        rdchk("R6 aeoi off", 1'b0, 8'h10);
        wr(1'b0, 8'h20);
        // R8: fourth word turns auto-EOI on
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h80);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h02);
        rdchk("R8 mask kept", 1'b1, 8'h0F);
        lines(8'h6A);
        lines(8'h7A);
        intchk("R4 line4 again", 1'b1, 8'h84);
        ack();
        rdchk("R6 aeoi on", 1'b0, 8'h00);
        intchk("R6 idle", 1'b0, 8'h00);
        repeat (2) cyc();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule